// File: doc/BRIEF.md
# I2C Target Receive Engine

This block is the receiving side of an I2C target. It watches the shared clock and data lines through a synchronizer and picks out START and STOP from data edges that occur while the clock is high. It then shifts in the address byte that follows a START. When the seven upper bits of that byte equal the programmed own address and the direction bit asks for a write, the block acknowledges, marks itself busy and accepts data bytes until the next START or STOP. Any other address leaves the block silent until the next START.

Each accepted data byte is placed in a data register, sets a buffer-full status flag and, if enabled, raises the interrupt. The block answers each data byte with an acknowledge and holds the clock line low after the byte. The clock is released only when software has read the data register and has set the hand-off bit in the control register. So the remote master can never overrun software. Status flags are cleared by writing one to them. A STOP seen while addressed is reported as its own status flag.

Top module: `i2c_target_rx`

## Requirements
- R1: An address byte whose bits [7:1] equal OWN[7:1] (register offset 3) and whose bit 0 is 0 is acknowledged by driving SDA low during the ninth clock pulse, and STAT bit 2 (busy) reads 1 until the transfer ends; an address byte with other upper bits gets no acknowledge, does not set busy and changes no status bit.
- R2: A matching address with bit 0 equal to 1 is not acknowledged and leaves busy at 0; STAT bit 4 holds bit 0 of the last matching address byte and STAT bit 3 reads 1 after a refused acknowledge and 0 after a given one.
- R3: Every data byte of an accepted write is acknowledged, appears in DATA (offset 2), and sets STAT bit 0 (buffer full).
- R4: The interrupt output equals (STAT bit 0 AND CTRL bit 1) OR (STAT bit 1 AND CTRL bit 2), with CTRL at offset 0.
- R5: After each data byte SCL is held low; writing CTRL bit 3 (hand-off) alone or reading DATA alone does not release it, and doing both releases it.
- R6: Writing 1 to STAT bit 0 or bit 1 clears that bit; writing 0 leaves it unchanged.
- R7: A STOP while busy sets STAT bit 1 and clears busy; a STOP while not busy leaves STAT bit 1 at 0.
- R8: With CTRL bit 0 (enable) at 0 no address is acknowledged.
- R9: After reset every register reads 0, the interrupt is low and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 CTRL, 1 STAT, 2 DATA, 3 OWN |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks DATA as read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe | output | 1 | SCL pull-low enable (clock hold) |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_oe | output | 1 | SDA pull-low enable (acknowledge) |

## Verification
A wrong bit count or a wrong state in the receive engine shows on the line within one byte: the acknowledge arrives in the wrong pulse, or it is missing, and the data register holds a shifted value. A wrong hand-off state shows at once as SCL released too early or never released. The bench catches the second case because the master waits for the line and the run never finishes. Flag errors show on the interrupt pin in the next cycle and in the STAT word at the next read.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Shared types and field positions for the I2C target receive engine.
// Assumes an 8-bit register bus with four word addresses.
package i2c_tgt_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_OWN  = 2'd3
    } reg_sel_e;

    // control bits
    localparam int CTRL_EN      = 0;
    localparam int CTRL_IE_RX   = 1;
    localparam int CTRL_IE_STOP = 2;
    localparam int CTRL_TB      = 3;

    // status bits
    localparam int SB_RXF  = 0;
    localparam int SB_STOP = 1;
    localparam int SB_BUSY = 2;
    localparam int SB_NAK  = 3;
    localparam int SB_RNW  = 4;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_ADDR,
        EN_ADDR_ACK,
        EN_DATA,
        EN_DATA_ACK,
        EN_SKIP
    } eng_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
// Line synchronizer and event detector.
// Passes SCL/SDA through STAGES flops, then reports clock edges and
// START/STOP (SDA edge while SCL stays high). Assumes idle-high lines.
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // shift the raw lines into the clock domain and keep one old copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    // decode edges from the synchronized copy and its delayed twin
    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// Bit-level receive engine.
// Shifts bits on SCL rise, decides at the falling edge that closes the
// eighth bit, and drives the acknowledge through the ninth pulse.
// Assumes events from i2c_tgt_sync; SCL hold is applied outside.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_ev_t      ev,
    input  logic          enable,
    input  logic [DW-1:1] own_addr,
    output logic          sda_drive,
    output logic          busy,
    output logic          cap,
    output logic [DW-1:0] cap_data,
    output logic          stop_hit,
    output logic          ack_upd,
    output logic          ack_nak,
    output logic          addr_upd,
    output logic          addr_rnw
);
    localparam int CW = $clog2(DW + 1);

    eng_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;

    assign cap_data = shreg;

    // byte framing, address decision and acknowledge timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= EN_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            sda_drive <= 1'b0;
            busy      <= 1'b0;
            cap       <= 1'b0;
            stop_hit  <= 1'b0;
            ack_upd   <= 1'b0;
            ack_nak   <= 1'b0;
            addr_upd  <= 1'b0;
            addr_rnw  <= 1'b0;
        end else begin
            cap      <= 1'b0;
            stop_hit <= 1'b0;
            ack_upd  <= 1'b0;
            addr_upd <= 1'b0;
            if (!enable) begin
                state     <= EN_IDLE;
                sda_drive <= 1'b0;
                busy      <= 1'b0;
            end else if (ev.stop) begin
                stop_hit  <= busy;
                busy      <= 1'b0;
                sda_drive <= 1'b0;
                state     <= EN_IDLE;
            end else if (ev.start) begin
                state     <= EN_ADDR;
                cnt       <= '0;
                sda_drive <= 1'b0;
            end else begin
                case (state)
                    EN_ADDR, EN_DATA: begin
                        if (ev.rise) begin
                            shreg <= {shreg[DW-2:0], ev.sda};
                            cnt   <= cnt + CW'(1);
                        end else if (ev.fall && cnt == CW'(DW)) begin
                            cnt <= '0;
                            if (state == EN_DATA) begin
                                cap       <= 1'b1;
                                ack_upd   <= 1'b1;
                                ack_nak   <= 1'b0;
                                sda_drive <= 1'b1;
                                state     <= EN_DATA_ACK;
                            end else if (shreg[DW-1:1] == own_addr) begin
                                addr_upd <= 1'b1;
                                addr_rnw <= shreg[0];
                                ack_upd  <= 1'b1;
                                ack_nak  <= shreg[0];
                                if (!shreg[0]) begin
                                    sda_drive <= 1'b1;
                                    busy      <= 1'b1;
                                    state     <= EN_ADDR_ACK;
                                end else begin
                                    busy  <= 1'b0;
                                    state <= EN_SKIP;
                                end
                            end else begin
                                busy  <= 1'b0;
                                state <= EN_SKIP;
                            end
                        end
                    end
                    EN_ADDR_ACK, EN_DATA_ACK: begin
                        if (ev.fall) begin
                            sda_drive <= 1'b0;
                            state     <= EN_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive |-> busy);

    // R1
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev.start && !ev.stop) |=> !sda_drive);
endmodule

// File: rtl/i2c_tgt_regs.sv
`timescale 1ns/1ps
// Register file, status flags, interrupt and byte hand-off control.
// Assumes single-cycle strobes; read data is combinational on reg_addr.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              cap,
    input  logic [DW-1:0]     cap_data,
    input  logic              stop_hit,
    input  logic              ack_upd,
    input  logic              ack_nak,
    input  logic              addr_upd,
    input  logic              addr_rnw,
    input  logic              busy,
    output logic              ctrl_en,
    output logic [DW-1:1]     own_addr,
    output logic              irq,
    output logic              hold
);
    logic          ie_rx, ie_stop;
    logic          rxfull, stopf, nak, rnw;
    logic          tb_pend, rd_done;
    logic [DW-1:0] rxbuf;
    logic          ctrl_wr, stat_wr, own_wr, data_rd;

    assign ctrl_wr = reg_wr && reg_addr == REG_CTRL;
    assign stat_wr = reg_wr && reg_addr == REG_STAT;
    assign own_wr  = reg_wr && reg_addr == REG_OWN;
    assign data_rd = reg_rd && reg_addr == REG_DATA;

    // software-written configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ie_rx    <= 1'b0;
            ie_stop  <= 1'b0;
            own_addr <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_en <= reg_wdata[CTRL_EN];
                ie_rx   <= reg_wdata[CTRL_IE_RX];
                ie_stop <= reg_wdata[CTRL_IE_STOP];
            end
            if (own_wr) own_addr <= reg_wdata[DW-1:1];
        end
    end

    // status flags: set by the engine, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxfull <= 1'b0;
            stopf  <= 1'b0;
            nak    <= 1'b0;
            rnw    <= 1'b0;
            rxbuf  <= '0;
        end else begin
            if (cap) rxfull <= 1'b1;
            else if (stat_wr && reg_wdata[SB_RXF]) rxfull <= 1'b0;
            if (stop_hit) stopf <= 1'b1;
            else if (stat_wr && reg_wdata[SB_STOP]) stopf <= 1'b0;
            if (ack_upd) nak <= ack_nak;
            if (addr_upd) rnw <= addr_rnw;
            if (cap) rxbuf <= cap_data;
        end
    end

    // clock hold from byte capture until both read and hand-off are seen
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) begin
            hold    <= 1'b0;
            tb_pend <= 1'b0;
            rd_done <= 1'b0;
        end else if (cap) begin
            hold    <= 1'b1;
            tb_pend <= 1'b0;
            rd_done <= 1'b0;
        end else if (hold) begin
            if (tb_pend && rd_done) begin
                hold    <= 1'b0;
                tb_pend <= 1'b0;
                rd_done <= 1'b0;
            end else begin
                if (ctrl_wr && reg_wdata[CTRL_TB]) tb_pend <= 1'b1;
                if (data_rd) rd_done <= 1'b1;
            end
        end
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_EN]      = ctrl_en;
                reg_rdata[CTRL_IE_RX]   = ie_rx;
                reg_rdata[CTRL_IE_STOP] = ie_stop;
            end
            REG_STAT: begin
                reg_rdata[SB_RXF]  = rxfull;
                reg_rdata[SB_STOP] = stopf;
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_NAK]  = nak;
                reg_rdata[SB_RNW]  = rnw;
            end
            REG_DATA: reg_rdata = rxbuf;
            default:  reg_rdata = {own_addr, 1'b0};
        endcase
    end

    // interrupt combine
    assign irq = (rxfull & ie_rx) | (stopf & ie_stop);

    // R3
    rxfull_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> rxfull);

    // R6
    w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[SB_RXF] && rxfull) |=> rxfull);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> ($past(tb_pend && rd_done) || !$past(ctrl_en)));

    // R7
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopf) |-> $past(busy, 2));
endmodule

// File: rtl/i2c_target_rx.sv
`timescale 1ns/1ps
// I2C target receive engine top.
// Joins synchronizer, bit engine and register file; drives both lines
// open-drain (value 0, enable = pull low). Assumes external pull-ups.
module i2c_target_rx
    import i2c_tgt_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    input  logic              scl_i,
    output logic              scl_o,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe
);
    line_ev_t      ev;
    logic          enable, sda_drive, busy, cap, stop_hit;
    logic          ack_upd, ack_nak, addr_upd, addr_rnw, hold;
    logic [DW-1:0] cap_data;
    logic [DW-1:1] own_addr;

    i2c_tgt_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i), .ev(ev)
    );

    i2c_tgt_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .ev(ev), .enable(enable),
        .own_addr(own_addr), .sda_drive(sda_drive), .busy(busy),
        .cap(cap), .cap_data(cap_data), .stop_hit(stop_hit),
        .ack_upd(ack_upd), .ack_nak(ack_nak),
        .addr_upd(addr_upd), .addr_rnw(addr_rnw)
    );

    i2c_tgt_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap(cap), .cap_data(cap_data), .stop_hit(stop_hit),
        .ack_upd(ack_upd), .ack_nak(ack_nak),
        .addr_upd(addr_upd), .addr_rnw(addr_rnw), .busy(busy),
        .ctrl_en(enable), .own_addr(own_addr), .irq(irq), .hold(hold)
    );

    assign scl_o  = 1'b0;
    assign sda_o  = 1'b0;
    assign scl_oe = hold;
    assign sda_oe = sda_drive;

    // R5
    hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> sda_oe);
endmodule

// File: tb/i2c_target_rx_test.sv
`timescale 1ns/1ps
module i2c_target_rx_test;
    localparam int Q = 6;
    localparam logic [6:0] OWN = 7'h5A;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_o, scl_oe, sda_o, sda_oe;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_line, sda_line;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_target_rx uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_i(scl_line), .scl_o(scl_o), .scl_oe(scl_oe),
        .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_up(); wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(Q);
            scl_up(); wait_q(Q);
            scl_m = 1'b0; wait_q(Q);
        end
        sda_m = 1'b1;
    endtask

    task automatic ack_pulse(output bit acked);
        scl_up(); wait_q(Q);
        acked = !sda_line;
        scl_m = 1'b0; wait_q(Q);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] ctrl_v;
        bit         acked;
        bit         exp_rnw, exp_nak, match;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        bus_read(A_CTRL, d); check(d == 8'h00, "R9 ctrl", d, 0);
        bus_read(A_STAT, d); check(d == 8'h00, "R9 stat", d, 0);
        bus_read(A_DATA, d); check(d == 8'h00, "R9 data", d, 0);
        bus_read(A_OWN, d);  check(d == 8'h00, "R9 own", d, 0);
        check(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R9 pins",
              {irq, scl_oe, sda_oe}, 0);

        bus_write(A_OWN, {OWN, 1'b0});
        bus_read(A_OWN, d); check(d == {OWN, 1'b0}, "R1 own readback", d, {OWN, 1'b0});
        ctrl_v = 8'h07;
        bus_write(A_CTRL, ctrl_v);

        // R2 matching read request is refused
        bus_start(); send_bits({OWN, 1'b1}); ack_pulse(acked);
        check(!acked, "R2 read not acked", acked, 0);
        bus_read(A_STAT, d); check(d == 8'h18, "R2 stat rnw/nak", d, 8'h18);
        bus_stop();
        bus_read(A_STAT, d); check(d == 8'h18, "R7 stop when idle", d, 8'h18);
        exp_rnw = 1'b1; exp_nak = 1'b1;

        // R1 R7 sweep over every 7-bit address
        for (int a = 0; a < 128; a++) begin
            match = (a[6:0] == OWN);
            bus_start(); send_bits({a[6:0], 1'b0}); ack_pulse(acked);
            check(acked == match, "R1 address ack", acked, match);
            if (match) begin exp_rnw = 1'b0; exp_nak = 1'b0; end
            bus_read(A_STAT, d);
            check(d == {3'b000, exp_rnw, exp_nak, match, 2'b00}, "R1 busy/status",
                  d, {3'b000, exp_rnw, exp_nak, match, 2'b00});
            bus_stop();
            bus_read(A_STAT, d);
            check(d == {3'b000, exp_rnw, exp_nak, 1'b0, match, 1'b0}, "R7 stop flag",
                  d, {3'b000, exp_rnw, exp_nak, 1'b0, match, 1'b0});
            if (match) bus_write(A_STAT, 8'h02);
        end

        // R3 R4 R5 R6 sweep over every data value in one transfer
        bus_start(); send_bits({OWN, 1'b0}); ack_pulse(acked);
        check(acked, "R1 address ack before data", acked, 1);
        for (int v = 0; v < 256; v++) begin
            send_bits(v[7:0]);
            scl_m = 1'b1; wait_q(3 * Q);
            check(scl_line == 1'b0, "R5 held after byte", scl_line, 0);
            bus_read(A_STAT, d);
            check(d == 8'h05, "R3 full flag", d, 8'h05);
            check(irq == ctrl_v[1], "R4 irq follows enable", irq, ctrl_v[1]);
            if (v == 0) begin
                bus_write(A_CTRL, ctrl_v | 8'h08); wait_q(3 * Q);
                check(scl_line == 1'b0, "R5 hand-off alone", scl_line, 0);
                bus_read(A_DATA, d);
                check(d == v[7:0], "R3 data", d, v);
            end else begin
                bus_read(A_DATA, d);
                check(d == v[7:0], "R3 data", d, v);
                wait_q(3 * Q);
                check(scl_line == 1'b0, "R5 read alone", scl_line, 0);
            end
            bus_write(A_STAT, 8'h00);
            bus_read(A_STAT, d); check(d[0] == 1'b1, "R6 write zero", d, 8'h05);
            bus_write(A_STAT, 8'h01);
            bus_read(A_STAT, d); check(d == 8'h04, "R6 write one", d, 8'h04);
            check(irq == 1'b0, "R4 irq after clear", irq, 0);
            if (v != 0) begin
                ctrl_v = v[1] ? 8'h07 : 8'h05;
                bus_write(A_CTRL, ctrl_v | 8'h08);
            end
            ack_pulse(acked);
            check(acked, "R3 data ack", acked, 1);
        end
        bus_stop();
        bus_read(A_STAT, d); check(d == 8'h02, "R7 stop after data", d, 8'h02);
        check(irq == 1'b1, "R4 stop irq", irq, 1);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, d); check(d == 8'h02, "R6 stop write zero", d, 8'h02);
        bus_write(A_STAT, 8'h02);
        bus_read(A_STAT, d); check(d == 8'h00, "R6 stop write one", d, 8'h00);
        check(irq == 1'b0, "R4 irq low", irq, 0);

        // R8 disabled unit stays silent
        bus_write(A_CTRL, 8'h00);
        bus_start(); send_bits({OWN, 1'b0}); ack_pulse(acked);
        check(!acked, "R8 disabled no ack", acked, 0);
        bus_stop();
        bus_read(A_STAT, d); check(d == 8'h00, "R8 stat unchanged", d, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule